// File: doc/BRIEF.md
# Ethernet MAC Register and Interrupt Unit

This block is the control and status front end of a small Ethernet MAC. A host reaches it over a simple 32-bit bus with a byte address, one-cycle write and read strobes, and read data that is valid in the same cycle as the read strobe. The unit holds the following state:

- the latched interrupt sources and their enable mask
- the receive and transmit control words
- the 48-bit station address
- the transmit threshold
- the management control, divider and transmit-data bytes
- the count of received packets waiting in the receive buffer

The transmit and receive datapaths raise interrupt sources with one-cycle event pulses. They step the packet count with push and pop pulses. They take from this unit their control fields and a set of one-cycle side-effect strobes: a data word pushed toward the transmit buffer, a data word popped from the receive buffer, a transmit start, a transmit buffer clear and a receive buffer reset. A single level interrupt output is high while any latched source is also enabled. Serial management signalling is not part of the block. A management transfer appears to finish at once.

The external reset is asynchronous and active low. It is released to the registers through a two-stage synchronizer, so the registers leave reset on the second rising clock edge after the external reset rises.

Top module: `mac_csr_unit`

## Requirements
- R1: Out of reset the registers hold these values: enable mask 0x7F, receive control 0x08, threshold 0x3F, management divider 0x80. Interrupt status, transmit control, both address words, management control, management transmit data and packet count are zero. The interrupt output is low.
- R2: Interrupt status bit positions are: receive 0, transmit error 1, transmit empty 2, overrun 3, receive error 4, management done 5, PHY 6. A pulse on `evt_set[i]` sets bit i on the next edge. The bit stays set until it is acknowledged. Status reads back at offset 0x00.
- R3: `irq` is high exactly when any bit of (status AND mask) is 1. It reflects a status or mask change from the clock edge that stores the change.
- R4: A write to offset 0x00 clears every status bit whose written data bit is 1 and leaves the other bits unchanged. When written bit 1 is 1, `tx_fifo_clr` pulses during that write cycle.
- R5: When a status bit gets a set pulse and an acknowledge in the same cycle, the bit ends set.
- R6: A write to offset 0x08 stores data bits 7:0 as receive control. When data bit 4 is 1, `rx_fifo_rst` pulses in that cycle and the packet count becomes zero, even if a push arrives in the same cycle.
- R7: A write to offset 0x20 stores data bits 7:0 as management control with bit 0 forced to 0.
- R8: Management transmit data at offset 0x2C keeps only data bits 7:0. The upper bits read as zero.
- R9: The packet count reads at offset 0x34. A lone `pkt_push` adds one, but not beyond 31. A lone `pkt_pop` subtracts one, but not below zero. Both together leave the count unchanged.
- R10: A write to offset 0x10 pulses `tx_word_push` in that cycle and presents the write data on `tx_word`. A read of offset 0x10 pulses `rx_word_pop` and returns `rx_word` in the same cycle.
- R11: A write to offset 0x38 with data bit 0 set pulses `tx_go`. Reads of offsets 0x28, 0x30, 0x38 and 0x3C return zero. Writes to offsets 0x28, 0x30, 0x34 and 0x3C change no state.
- R12: An access to a misaligned address, or to any address at 0x40 or above, reads zero and changes no state. It pulses `bus_err` in the access cycle. Mapped accesses never raise `bus_err`.
- R13: Writes are stored and read back as follows. Offset 0x04 stores the mask from data bits 6:0. Offset 0x0C stores transmit control from bits 7:0. Offset 0x1C stores the threshold from bits 5:0. Offset 0x24 stores the divider from bits 7:0. Offset 0x14 stores address bytes 0-3. Offset 0x18 stores address bytes 4-5 from bits 15:0. `mac_addr` = {word 0x18 bits 15:0, word 0x14}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| bus_err | output | 1 | Pulse for an access to an unmapped address |
| evt_set | input | EVT_W | Interrupt source set pulses |
| irq | output | 1 | Level interrupt |
| pkt_push | input | 1 | A received packet entered the buffer |
| pkt_pop | input | 1 | A received packet left the buffer |
| rx_word | input | 32 | Next receive-buffer word from the datapath |
| rx_word_pop | output | 1 | Receive word consumed by a data read |
| tx_word_push | output | 1 | Transmit word written by a data write |
| tx_word | output | 32 | Transmit word |
| tx_fifo_clr | output | 1 | Transmit buffer clear strobe |
| rx_fifo_rst | output | 1 | Receive buffer reset strobe |
| tx_go | output | 1 | Transmit start strobe |
| rx_ctl | output | CTL_W | Receive control field |
| tx_ctl | output | CTL_W | Transmit control field |
| mac_addr | output | 48 | Station address |
| tx_thresh | output | THR_W | Transmit threshold |
| mgmt_ctl | output | CTL_W | Management control |
| mgmt_div | output | CTL_W | Management clock divider |
| mgmt_txd | output | 8 | Management transmit data |

## Verification
A status bit that is lost or latched by mistake shows on `irq` at the next clock edge when that source is enabled. It also shows on the next read of offset 0x00. A masked source shows up only through the status read, so reads are mixed in all through the random traffic. A wrong packet count is hidden until offset 0x34 is read. It can then be off by one after a saturating push, a pop at zero, or a buffer reset that collides with a push. A wrong decode shows in the access cycle itself, as a stray strobe, a wrong `bus_err`, or a control field that changes on the following edge when it should not.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

  localparam int BUS_W     = 32;
  localparam int SLOT_BITS = 4;

  typedef enum logic [SLOT_BITS-1:0] {
    SLOT_STATUS   = 4'h0,
    SLOT_MASK     = 4'h1,
    SLOT_RXCTL    = 4'h2,
    SLOT_TXCTL    = 4'h3,
    SLOT_DATA     = 4'h4,
    SLOT_ADDR_LO  = 4'h5,
    SLOT_ADDR_HI  = 4'h6,
    SLOT_THRESH   = 4'h7,
    SLOT_MG_CTL   = 4'h8,
    SLOT_MG_DIV   = 4'h9,
    SLOT_MG_REG   = 4'hA,
    SLOT_MG_TXD   = 4'hB,
    SLOT_MG_RXD   = 4'hC,
    SLOT_PKTCNT   = 4'hD,
    SLOT_TXGO     = 4'hE,
    SLOT_SPARE    = 4'hF
  } csr_slot_e;

  localparam int EVT_TXERR_BIT  = 1;
  localparam int RXCTL_RST_BIT  = 4;
  localparam int MGMT_START_BIT = 0;
  localparam int TXGO_BIT       = 0;

endpackage

// File: rtl/mac_csr_decode.sv
module mac_csr_decode
  import mac_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit,
  output csr_slot_e         slot,
  output logic              err
);

  localparam int LOW_BITS = 2;
  localparam int TOP_LSB  = LOW_BITS + SLOT_BITS;

  logic mapped;

  always_comb begin
    mapped = (addr[LOW_BITS-1:0] == '0) && (addr[ADDR_W-1:TOP_LSB] == '0);
    slot   = csr_slot_e'(addr[TOP_LSB-1:LOW_BITS]);
    wr_hit = wr && mapped;
    rd_hit = rd && mapped;
    err    = (wr || rd) && !mapped;
  end

  always_comb begin
    if (err) begin
      assert_err_excludes_hit_R12: assert (!wr_hit && !rd_hit);
    end
  end

endmodule

// File: rtl/mac_csr_irq.sv
module mac_csr_irq #(
  parameter int             EVT_W    = 7,
  parameter logic [EVT_W-1:0] MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic             ack_we,
  input  logic [EVT_W-1:0] ack_bits,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_bits,
  output logic [EVT_W-1:0] status,
  output logic [EVT_W-1:0] mask,
  output logic             irq
);

  logic [EVT_W-1:0] status_q, status_d;
  logic [EVT_W-1:0] mask_q, mask_d;
  logic             status_en, mask_en;

  always_comb begin
    status_en = ack_we || (evt_set != '0);
    status_d  = status_q;
    if (ack_we) begin
      status_d = status_d & ~ack_bits;
    end
    status_d = status_d | evt_set;
    mask_en  = mask_we;
    mask_d   = mask_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
    end else begin
      if (status_en) status_q <= status_d;
      if (mask_en)   mask_q   <= mask_d;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = |(status_q & mask_q);

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((status_q & $past(ack_bits & ~evt_set)) == '0));

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && evt_set == '0) |=> $stable(status_q));

  assert_mask_store_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_bits)));

endmodule

// File: rtl/mac_csr_ctrl.sv
module mac_csr_ctrl
  import mac_csr_pkg::*;
#(
  parameter int CTL_W = 8,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_rxctl,
  input  logic             we_txctl,
  input  logic             we_addr_lo,
  input  logic             we_addr_hi,
  input  logic             we_thresh,
  input  logic             we_mg_ctl,
  input  logic             we_mg_div,
  input  logic             we_mg_txd,
  input  logic [BUS_W-1:0] wdata,
  output logic [CTL_W-1:0] rx_ctl,
  output logic [CTL_W-1:0] tx_ctl,
  output logic [47:0]      mac_addr,
  output logic [THR_W-1:0] thresh,
  output logic [CTL_W-1:0] mg_ctl,
  output logic [CTL_W-1:0] mg_div,
  output logic [7:0]       mg_txd
);

  localparam logic [CTL_W-1:0] RXCTL_RST  = CTL_W'(8'h08);
  localparam logic [CTL_W-1:0] MGDIV_RST  = CTL_W'(8'h80);
  localparam logic [THR_W-1:0] THRESH_RST = '1;
  localparam int               HI_W       = 16;

  logic [CTL_W-1:0] rx_ctl_q, rx_ctl_d;
  logic [CTL_W-1:0] tx_ctl_q, tx_ctl_d;
  logic [BUS_W-1:0] addr_lo_q, addr_lo_d;
  logic [HI_W-1:0]  addr_hi_q, addr_hi_d;
  logic [THR_W-1:0] thresh_q, thresh_d;
  logic [CTL_W-1:0] mg_ctl_q, mg_ctl_d;
  logic [CTL_W-1:0] mg_div_q, mg_div_d;
  logic [7:0]       mg_txd_q, mg_txd_d;

  always_comb begin
    rx_ctl_d  = wdata[CTL_W-1:0];
    tx_ctl_d  = wdata[CTL_W-1:0];
    addr_lo_d = wdata;
    addr_hi_d = wdata[HI_W-1:0];
    thresh_d  = wdata[THR_W-1:0];
    mg_ctl_d  = wdata[CTL_W-1:0];
    mg_ctl_d[MGMT_START_BIT] = 1'b0;
    mg_div_d  = wdata[CTL_W-1:0];
    mg_txd_d  = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ctl_q  <= RXCTL_RST;
      tx_ctl_q  <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      thresh_q  <= THRESH_RST;
      mg_ctl_q  <= '0;
      mg_div_q  <= MGDIV_RST;
      mg_txd_q  <= '0;
    end else begin
      if (we_rxctl)   rx_ctl_q  <= rx_ctl_d;
      if (we_txctl)   tx_ctl_q  <= tx_ctl_d;
      if (we_addr_lo) addr_lo_q <= addr_lo_d;
      if (we_addr_hi) addr_hi_q <= addr_hi_d;
      if (we_thresh)  thresh_q  <= thresh_d;
      if (we_mg_ctl)  mg_ctl_q  <= mg_ctl_d;
      if (we_mg_div)  mg_div_q  <= mg_div_d;
      if (we_mg_txd)  mg_txd_q  <= mg_txd_d;
    end
  end

  assign rx_ctl   = rx_ctl_q;
  assign tx_ctl   = tx_ctl_q;
  assign mac_addr = {addr_hi_q, addr_lo_q};
  assign thresh   = thresh_q;
  assign mg_ctl   = mg_ctl_q;
  assign mg_div   = mg_div_q;
  assign mg_txd   = mg_txd_q;

  assert_mgmt_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_mg_ctl |=> (mg_ctl == {$past(wdata[CTL_W-1:1]), 1'b0}));

  assert_txd_low_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_mg_txd |=> (mg_txd == $past(wdata[7:0])));

  assert_fields_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_rxctl || we_txctl || we_addr_lo || we_addr_hi || we_thresh ||
      we_mg_ctl || we_mg_div || we_mg_txd)
    |=> ($stable(rx_ctl) && $stable(tx_ctl) && $stable(mac_addr) &&
         $stable(thresh) && $stable(mg_ctl) && $stable(mg_div) && $stable(mg_txd)));

endmodule

// File: rtl/mac_csr_pktcnt.sv
module mac_csr_pktcnt #(
  parameter int MAX_PKT = 31,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (flush) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (push && !pop && cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (pop && !push && cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);

  assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && count == CNT_MAX) |=> (count == CNT_MAX));

  assert_cnt_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && count == '0) |=> (count == '0));

endmodule

// File: rtl/mac_csr_unit.sv
module mac_csr_unit
  import mac_csr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int EVT_W   = 7,
  parameter int CTL_W   = 8,
  parameter int THR_W   = 6,
  parameter int MAX_PKT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [EVT_W-1:0]  evt_set,
  output logic              irq,
  input  logic              pkt_push,
  input  logic              pkt_pop,
  input  logic [31:0]       rx_word,
  output logic              rx_word_pop,
  output logic              tx_word_push,
  output logic [31:0]       tx_word,
  output logic              tx_fifo_clr,
  output logic              rx_fifo_rst,
  output logic              tx_go,
  output logic [CTL_W-1:0]  rx_ctl,
  output logic [CTL_W-1:0]  tx_ctl,
  output logic [47:0]       mac_addr,
  output logic [THR_W-1:0]  tx_thresh,
  output logic [CTL_W-1:0]  mgmt_ctl,
  output logic [CTL_W-1:0]  mgmt_div,
  output logic [7:0]        mgmt_txd
);

  localparam int               CNT_W    = $clog2(MAX_PKT + 1);
  localparam logic [EVT_W-1:0] MASK_RST = '1;

  logic        rst_meta_q, rst_sync_q;
  logic        wr_hit, rd_hit, dec_err;
  csr_slot_e   slot;
  logic [EVT_W-1:0] status, mask;
  logic [CNT_W-1:0] pkt_cnt;
  logic        we_status, we_mask, we_rxctl;
  logic        flush_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mac_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit),
    .slot   (slot),
    .err    (dec_err)
  );

  always_comb begin
    we_status    = wr_hit && (slot == SLOT_STATUS);
    we_mask      = wr_hit && (slot == SLOT_MASK);
    we_rxctl     = wr_hit && (slot == SLOT_RXCTL);
    flush_rx     = we_rxctl && bus_wdata[RXCTL_RST_BIT];
    tx_fifo_clr  = we_status && bus_wdata[EVT_TXERR_BIT];
    rx_fifo_rst  = flush_rx;
    tx_word_push = wr_hit && (slot == SLOT_DATA);
    rx_word_pop  = rd_hit && (slot == SLOT_DATA);
    tx_go        = wr_hit && (slot == SLOT_TXGO) && bus_wdata[TXGO_BIT];
    tx_word      = bus_wdata;
    bus_err      = dec_err;
  end

  mac_csr_irq #(.EVT_W(EVT_W), .MASK_RST(MASK_RST)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .evt_set   (evt_set),
    .ack_we    (we_status),
    .ack_bits  (bus_wdata[EVT_W-1:0]),
    .mask_we   (we_mask),
    .mask_bits (bus_wdata[EVT_W-1:0]),
    .status    (status),
    .mask      (mask),
    .irq       (irq)
  );

  mac_csr_ctrl #(.CTL_W(CTL_W), .THR_W(THR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .we_rxctl   (we_rxctl),
    .we_txctl   (wr_hit && (slot == SLOT_TXCTL)),
    .we_addr_lo (wr_hit && (slot == SLOT_ADDR_LO)),
    .we_addr_hi (wr_hit && (slot == SLOT_ADDR_HI)),
    .we_thresh  (wr_hit && (slot == SLOT_THRESH)),
    .we_mg_ctl  (wr_hit && (slot == SLOT_MG_CTL)),
    .we_mg_div  (wr_hit && (slot == SLOT_MG_DIV)),
    .we_mg_txd  (wr_hit && (slot == SLOT_MG_TXD)),
    .wdata      (bus_wdata),
    .rx_ctl     (rx_ctl),
    .tx_ctl     (tx_ctl),
    .mac_addr   (mac_addr),
    .thresh     (tx_thresh),
    .mg_ctl     (mgmt_ctl),
    .mg_div     (mgmt_div),
    .mg_txd     (mgmt_txd)
  );

  mac_csr_pktcnt #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_pktcnt (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .push  (pkt_push),
    .pop   (pkt_pop),
    .flush (flush_rx),
    .count (pkt_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (slot)
        SLOT_STATUS:  bus_rdata = {{(BUS_W-EVT_W){1'b0}}, status};
        SLOT_MASK:    bus_rdata = {{(BUS_W-EVT_W){1'b0}}, mask};
        SLOT_RXCTL:   bus_rdata = {{(BUS_W-CTL_W){1'b0}}, rx_ctl};
        SLOT_TXCTL:   bus_rdata = {{(BUS_W-CTL_W){1'b0}}, tx_ctl};
        SLOT_DATA:    bus_rdata = rx_word;
        SLOT_ADDR_LO: bus_rdata = mac_addr[31:0];
        SLOT_ADDR_HI: bus_rdata = {16'h0000, mac_addr[47:32]};
        SLOT_THRESH:  bus_rdata = {{(BUS_W-THR_W){1'b0}}, tx_thresh};
        SLOT_MG_CTL:  bus_rdata = {{(BUS_W-CTL_W){1'b0}}, mgmt_ctl};
        SLOT_MG_DIV:  bus_rdata = {{(BUS_W-CTL_W){1'b0}}, mgmt_div};
        SLOT_MG_TXD:  bus_rdata = {24'h000000, mgmt_txd};
        SLOT_PKTCNT:  bus_rdata = {{(BUS_W-CNT_W){1'b0}}, pkt_cnt};
        default:      bus_rdata = '0;
      endcase
    end
  end

  assert_err_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bus_err |-> (bus_rdata == '0 && !tx_word_push && !rx_word_pop && !tx_go &&
                 !tx_fifo_clr && !rx_fifo_rst));

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (evt_set != '0 && ((evt_set & mask) != '0) && !we_mask) |=> irq);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones({tx_word_push, rx_word_pop, tx_go, tx_fifo_clr, rx_fifo_rst}) <= 2);

endmodule

// File: tb/mac_csr_unit_bench.sv
module mac_csr_unit_bench;

  localparam int ADDR_W = 12;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_err;
  logic [6:0]        evt_set;
  logic              irq;
  logic              pkt_push, pkt_pop;
  logic [31:0]       rx_word;
  logic              rx_word_pop, tx_word_push;
  logic [31:0]       tx_word;
  logic              tx_fifo_clr, rx_fifo_rst, tx_go;
  logic [7:0]        rx_ctl, tx_ctl, mgmt_ctl, mgmt_div, mgmt_txd;
  logic [47:0]       mac_addr;
  logic [5:0]        tx_thresh;

  mac_csr_unit u_mac_csr_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .evt_set(evt_set), .irq(irq), .pkt_push(pkt_push), .pkt_pop(pkt_pop),
    .rx_word(rx_word), .rx_word_pop(rx_word_pop), .tx_word_push(tx_word_push),
    .tx_word(tx_word), .tx_fifo_clr(tx_fifo_clr), .rx_fifo_rst(rx_fifo_rst),
    .tx_go(tx_go), .rx_ctl(rx_ctl), .tx_ctl(tx_ctl), .mac_addr(mac_addr),
    .tx_thresh(tx_thresh), .mgmt_ctl(mgmt_ctl), .mgmt_div(mgmt_div), .mgmt_txd(mgmt_txd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  logic [6:0]  m_ris, m_im;
  logic [7:0]  m_rctl, m_tctl, m_mctl, m_mdv, m_mtxd;
  logic [31:0] m_ia0;
  logic [15:0] m_ia1;
  logic [5:0]  m_thr;
  int          m_np;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_mapped(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (a[ADDR_W-1:6] == '0);
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a, input logic [31:0] rw);
    if (!is_mapped(a)) return 32'h0;
    case (a[5:2])
      4'h0: return {25'h0, m_ris};
      4'h1: return {25'h0, m_im};
      4'h2: return {24'h0, m_rctl};
      4'h3: return {24'h0, m_tctl};
      4'h4: return rw;
      4'h5: return m_ia0;
      4'h6: return {16'h0, m_ia1};
      4'h7: return {26'h0, m_thr};
      4'h8: return {24'h0, m_mctl};
      4'h9: return {24'h0, m_mdv};
      4'hB: return {24'h0, m_mtxd};
      4'hD: return 32'(m_np);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [ADDR_W-1:0] a);
    if (!is_mapped(a)) return "R12";
    case (a[5:2])
      4'h0: return "R2";
      4'h4: return "R10";
      4'h8: return "R7";
      4'hB: return "R8";
      4'hD: return "R9";
      4'hA, 4'hC, 4'hE, 4'hF: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic model_reset();
    m_ris = '0; m_im = 7'h7F; m_rctl = 8'h08; m_tctl = '0; m_ia0 = '0; m_ia1 = '0;
    m_thr = 6'h3F; m_mctl = '0; m_mdv = 8'h80; m_mtxd = '0; m_np = 0;
  endtask

  task automatic step(input bit wr, input bit rd, input logic [ADDR_W-1:0] a,
                      input logic [31:0] wd, input logic [6:0] ev,
                      input bit push, input bit pop, input string rtag);
    bit         hit;
    logic [3:0] ix;
    logic [6:0] ack;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; evt_set = ev;
    pkt_push = push; pkt_pop = pop; rx_word = $urandom;
    #2;
    hit = is_mapped(a);
    ix  = a[5:2];
    chk("R12", 64'(bus_err), 64'((wr || rd) && !hit));
    chk("R4",  64'(tx_fifo_clr), 64'(wr && hit && ix == 4'h0 && wd[1]));
    chk("R6",  64'(rx_fifo_rst), 64'(wr && hit && ix == 4'h2 && wd[4]));
    chk("R10", 64'(tx_word_push), 64'(wr && hit && ix == 4'h4));
    chk("R10", 64'(rx_word_pop), 64'(rd && hit && ix == 4'h4));
    chk("R11", 64'(tx_go), 64'(wr && hit && ix == 4'hE && wd[0]));
    if (wr && hit && ix == 4'h4) chk("R10", 64'(tx_word), 64'(wd));
    if (rd) chk(rtag, 64'(bus_rdata), 64'(exp_read(a, rx_word)));
    @(posedge clk);
    #1;
    ack = (wr && hit && ix == 4'h0) ? wd[6:0] : 7'h0;
    m_ris = (m_ris & ~ack) | ev;
    if (wr && hit) begin
      case (ix)
        4'h1: m_im   = wd[6:0];
        4'h2: m_rctl = wd[7:0];
        4'h3: m_tctl = wd[7:0];
        4'h5: m_ia0  = wd;
        4'h6: m_ia1  = wd[15:0];
        4'h7: m_thr  = wd[5:0];
        4'h8: m_mctl = {wd[7:1], 1'b0};
        4'h9: m_mdv  = wd[7:0];
        4'hB: m_mtxd = wd[7:0];
        default: ;
      endcase
    end
    if (wr && hit && ix == 4'h2 && wd[4]) m_np = 0;
    else if (push && !pop && m_np < 31) m_np++;
    else if (pop && !push && m_np > 0) m_np--;
    chk("R3",  64'(irq), 64'(|(m_ris & m_im)));
    chk("R6",  64'(rx_ctl), 64'(m_rctl));
    chk("R13", 64'(tx_ctl), 64'(m_tctl));
    chk("R13", 64'(mac_addr), 64'({m_ia1, m_ia0}));
    chk("R13", 64'(tx_thresh), 64'(m_thr));
    chk("R7",  64'(mgmt_ctl), 64'(m_mctl));
    chk("R13", 64'(mgmt_div), 64'(m_mdv));
    chk("R8",  64'(mgmt_txd), 64'(m_mtxd));
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    step(1, 0, a, d, 7'h0, 0, 0, "");
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, input string tag);
    step(0, 1, a, 32'h0, 7'h0, 0, 0, tag);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    evt_set = '0; pkt_push = 0; pkt_pop = 0; rx_word = '0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset values at every slot
    chk("R1", 64'(irq), 64'(0));
    for (int i = 0; i < 16; i++) begin
      if (i != 4) rd_reg(ADDR_W'(i * 4), "R1");
    end

    // R3: mask off, event, then enable
    wr_reg(12'h004, 32'h0);
    step(0, 0, 12'h000, 32'h0, 7'h08, 0, 0, "");
    chk("R3", 64'(irq), 64'(0));
    wr_reg(12'h004, 32'h08);
    chk("R3", 64'(irq), 64'(1));
    wr_reg(12'h004, 32'h7F);

    // R5: set and ack same bit in one cycle
    step(1, 0, 12'h000, 32'h0000_0008, 7'h08, 0, 0, "");
    rd_reg(12'h000, "R5");
    // R4: ack with transmit error bit
    step(0, 0, 12'h000, 32'h0, 7'h02, 0, 0, "");
    wr_reg(12'h000, 32'hFFFF_FFFF);
    rd_reg(12'h000, "R4");

    // R9: saturation and floor
    for (int i = 0; i < 33; i++) step(0, 0, 12'h000, 32'h0, 7'h0, 1, 0, "");
    rd_reg(12'h034, "R9");
    step(0, 0, 12'h000, 32'h0, 7'h0, 1, 1, "");
    rd_reg(12'h034, "R9");
    for (int i = 0; i < 33; i++) step(0, 0, 12'h000, 32'h0, 7'h0, 0, 1, "");
    rd_reg(12'h034, "R9");

    // R6: buffer reset colliding with a push
    for (int i = 0; i < 5; i++) step(0, 0, 12'h000, 32'h0, 7'h0, 1, 0, "");
    step(1, 0, 12'h008, 32'h0000_0019, 7'h0, 1, 0, "");
    rd_reg(12'h034, "R6");

    // R7, R8
    wr_reg(12'h020, 32'hFFFF_FFFF);
    rd_reg(12'h020, "R7");
    wr_reg(12'h02C, 32'h1234_ABCD);
    rd_reg(12'h02C, "R8");

    // R11: ignored writes and zero reads
    for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 32'h0, 7'h0, 1, 0, "");
    wr_reg(12'h034, 32'h0);
    rd_reg(12'h034, "R11");
    wr_reg(12'h030, 32'hFF); wr_reg(12'h03C, 32'hFF); wr_reg(12'h028, 32'hFF);
    rd_reg(12'h030, "R11"); rd_reg(12'h03C, "R11"); rd_reg(12'h038, "R11");
    wr_reg(12'h038, 32'h1);

    // R12: unmapped and misaligned
    wr_reg(12'h040, 32'hDEAD_BEEF);
    wr_reg(12'h006, 32'hFFFF_FFFF);
    rd_reg(12'h040, "R12");
    rd_reg(12'hFFC, "R12");

    // R10 and random traffic
    rd_reg(12'h010, "R10");
    wr_reg(12'h010, 32'hCAFE_F00D);
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      int op;
      op = $urandom_range(0, 9);
      a  = ($urandom_range(0, 9) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(0, 15) * 4);
      d  = $urandom;
      if (a == 12'h008 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
      if (op < 4)
        step(1, 0, a, d, ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, "");
      else if (op < 8)
        step(0, 1, a, 32'h0, ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, read_tag(a));
      else
        step(0, 0, a, 32'h0, 7'($urandom), $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, "");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule